// File: doc/BRIEF.md
# Two-Port Banked Scratchpad Memory

This block is a data scratchpad shared by two requesters. Storage is spread across eight single-ported banks, each 32 bits wide. Each port issues at most one 64-bit read or write per cycle. A 64-bit doubleword is held in an adjacent pair of banks, so when the two ports use disjoint banks, both accesses complete in the same cycle. This covers two reads as well as a read together with a write.

A single bank can carry out only one operation per clock. When the two ports need a common bank in the same cycle, the block serializes the pair. Port 0 runs at once. The port 1 request is captured internally and runs in the next cycle. During that second cycle the `stall` output is high.

While `stall` is high, the block accepts no new requests on either port. Throughput therefore depends on where the two data streams sit in memory: arrays whose doublewords fall in different bank pairs run at full rate, and arrays that collide lose a cycle for every collision.

Top module: `banked_dp_mem`

## Requirements
- R1: After reset, and until a request is accepted, `stall`, `p0_rvalid` and `p1_rvalid` are low.
- R2: The byte address is decoded as follows. Bits [2:0] are ignored. Bits [4:3] select bank pair k, which is banks 2k and 2k+1. Bits [ADDR_W-1:5] select the row. Bank 2k holds bytes 0-3 of the doubleword (data bits 31:0), and bank 2k+1 holds bytes 4-7 (bits 63:32).
- R3: A read that is executed at clock edge T returns its data on the port's `rdata` at edge T+1. `rvalid` is high for that single cycle. No `rvalid` appears without an executed read.
- R4: On a write, byte enable bit i gates data bits 8i+7:8i, and bytes whose enable is 0 keep their old value. A read ignores the byte enables and always returns all 8 bytes.
- R5: When both ports are valid and their bank sets are disjoint, both accesses execute at the same edge and `stall` stays low.
- R6: When the bank sets overlap, port 0 executes at edge T and port 1 executes at edge T+1. `stall` is high for exactly the one cycle between edges T and T+1. A port 1 read in this case returns at T+2.
- R7: A read uses both banks of its pair. A write uses bank 2k only if any of be[3:0] is set, and bank 2k+1 only if any of be[7:4] is set. Two writes to opposite halves of one doubleword therefore do not conflict, while two writes to the same half do conflict.
- R8: If both ports write the same bytes in a conflicting cycle, the bytes end up holding port 1's data.
- R9: Requests presented while `stall` is high are ignored. They do not change memory and produce no `rvalid`.
- R10: If port 0 writes a doubleword and port 1 reads the same doubleword in the same cycle, port 1 returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p0_valid | input | 1 | Port 0 request valid |
| p0_we | input | 1 | Port 0 write (1) or read (0) |
| p0_addr | input | ADDR_W | Port 0 byte address |
| p0_wdata | input | 64 | Port 0 write data |
| p0_be | input | 8 | Port 0 byte enables |
| p0_rdata | output | 64 | Port 0 read data |
| p0_rvalid | output | 1 | Port 0 read data valid |
| p1_valid | input | 1 | Port 1 request valid |
| p1_we | input | 1 | Port 1 write (1) or read (0) |
| p1_addr | input | ADDR_W | Port 1 byte address |
| p1_wdata | input | 64 | Port 1 write data |
| p1_be | input | 8 | Port 1 byte enables |
| p1_rdata | output | 64 | Port 1 read data |
| p1_rvalid | output | 1 | Port 1 read data valid |
| stall | output | 1 | Port 1 request held; no request accepted this cycle |

## Verification
Some internal faults show up one cycle after the fault:
- A wrong bank-use mask or overlap test shows as a `stall` that is missing or spurious on the very next cycle.
- A stuck stall flag shows as `stall` held for two cycles, or as a read that gets an `rvalid` while it should have been ignored.

Other faults surface later. A corrupted held request, or a wrong bank routing, only shows when the affected doubleword is read back. That can be many cycles afterwards, so the bench keeps a reference image of every doubleword and compares every returned read against it.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
  localparam int BANK_W   = 32;
  localparam int N_BANKS  = 8;
  localparam int LANE_W   = 2 * BANK_W;
  localparam int BE_W     = LANE_W / 8;
  localparam int BANK_BE  = BANK_W / 8;
  localparam int N_PAIRS  = N_BANKS / 2;
  localparam int PAIR_W   = $clog2(N_PAIRS);
  localparam int OFF_W    = $clog2(BE_W);
  localparam int ROW_LSB  = OFF_W + PAIR_W;

  typedef struct packed {
    logic              we;
    logic [PAIR_W-1:0] pair;
    logic [BE_W-1:0]   be;
    logic [LANE_W-1:0] wdata;
  } lane_op_t;

  // Banks an operation occupies: reads take the whole pair,
  // writes only the halves with any byte enabled.
  function automatic logic [N_BANKS-1:0] bank_use(lane_op_t op);
    logic [N_BANKS-1:0] m;
    m = '0;
    for (int k = 0; k < N_PAIRS; k++) begin
      if (op.pair == PAIR_W'(k)) begin
        if (op.we) begin
          m[2*k]   = |op.be[BANK_BE-1:0];
          m[2*k+1] = |op.be[BE_W-1:BANK_BE];
        end else begin
          m[2*k]   = 1'b1;
          m[2*k+1] = 1'b1;
        end
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/bdm_bank.sv
module bdm_bank #(
  parameter int ROW_W  = 7,
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  en,
  input  logic                  we,
  input  logic [WORD_W/8-1:0]   be,
  input  logic [ROW_W-1:0]      row,
  input  logic [WORD_W-1:0]     wdata,
  output logic [WORD_W-1:0]     rdata
);
  localparam int DEPTH = 2 ** ROW_W;
  localparam int NB    = WORD_W / 8;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        for (int i = 0; i < NB; i++) begin
          if (be[i]) mem[row][8*i +: 8] <= wdata[8*i +: 8];
        end
      end else begin
        rdata_q <= mem[row];
      end
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/bdm_arb.sv
module bdm_arb
  import bdm_pkg::*;
#(
  parameter int ROW_W = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 p0_vld,
  input  lane_op_t             p0_op,
  input  logic [ROW_W-1:0]     p0_row,
  input  logic                 p1_vld,
  input  lane_op_t             p1_op,
  input  logic [ROW_W-1:0]     p1_row,
  output logic                 x0_vld,
  output lane_op_t             x0_op,
  output logic [ROW_W-1:0]     x0_row,
  output logic [N_BANKS-1:0]   x0_use,
  output logic                 x1_vld,
  output lane_op_t             x1_op,
  output logic [ROW_W-1:0]     x1_row,
  output logic [N_BANKS-1:0]   x1_use,
  output logic                 stall
);
  logic               stall_q, stall_d;
  lane_op_t           hold_op_q;
  logic [ROW_W-1:0]   hold_row_q;
  logic               hold_en;
  logic               acc0, acc1, clash;
  logic [N_BANKS-1:0] u0, u1;

  always_comb begin
    acc0  = p0_vld & ~stall_q;
    acc1  = p1_vld & ~stall_q;
    u0    = bank_use(p0_op);
    u1    = bank_use(p1_op);
    clash = acc0 & acc1 & (|(u0 & u1));

    x0_vld = acc0;
    x0_op  = p0_op;
    x0_row = p0_row;
    x0_use = acc0 ? u0 : '0;

    if (stall_q) begin
      x1_vld = 1'b1;
      x1_op  = hold_op_q;
      x1_row = hold_row_q;
      x1_use = bank_use(hold_op_q);
    end else begin
      x1_vld = acc1 & ~clash;
      x1_op  = p1_op;
      x1_row = p1_row;
      x1_use = (acc1 & ~clash) ? u1 : '0;
    end

    stall_d = clash;
    hold_en = clash;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= stall_d;
  end

  always_ff @(posedge clk) begin
    if (hold_en) begin
      hold_op_q  <= p1_op;
      hold_row_q <= p1_row;
    end
  end

  assign stall = stall_q;
endmodule

// File: rtl/banked_dp_mem.sv
module banked_dp_mem
  import bdm_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p0_valid,
  input  logic              p0_we,
  input  logic [ADDR_W-1:0] p0_addr,
  input  logic [63:0]       p0_wdata,
  input  logic [7:0]        p0_be,
  output logic [63:0]       p0_rdata,
  output logic              p0_rvalid,
  input  logic              p1_valid,
  input  logic              p1_we,
  input  logic [ADDR_W-1:0] p1_addr,
  input  logic [63:0]       p1_wdata,
  input  logic [7:0]        p1_be,
  output logic [63:0]       p1_rdata,
  output logic              p1_rvalid,
  output logic              stall
);
  localparam int ROW_W = ADDR_W - ROW_LSB;

  lane_op_t           p0_op, p1_op, x0_op, x1_op;
  logic [ROW_W-1:0]   x0_row, x1_row;
  logic [N_BANKS-1:0] x0_use, x1_use;
  logic               x0_vld, x1_vld;
  logic [BANK_W-1:0]  bank_rd [N_BANKS];

  logic               rv0_q, rv1_q, rv0_d, rv1_d;
  logic [PAIR_W-1:0]  pair0_q, pair1_q;
  logic               unused_lo;

  assign unused_lo = ^{p0_addr[OFF_W-1:0], p1_addr[OFF_W-1:0]};

  always_comb begin
    p0_op.we    = p0_we;
    p0_op.pair  = p0_addr[ROW_LSB-1:OFF_W];
    p0_op.be    = p0_be;
    p0_op.wdata = p0_wdata;
    p1_op.we    = p1_we;
    p1_op.pair  = p1_addr[ROW_LSB-1:OFF_W];
    p1_op.be    = p1_be;
    p1_op.wdata = p1_wdata;
  end

  bdm_arb #(.ROW_W(ROW_W)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .p0_vld (p0_valid),
    .p0_op  (p0_op),
    .p0_row (p0_addr[ADDR_W-1:ROW_LSB]),
    .p1_vld (p1_valid),
    .p1_op  (p1_op),
    .p1_row (p1_addr[ADDR_W-1:ROW_LSB]),
    .x0_vld (x0_vld),
    .x0_op  (x0_op),
    .x0_row (x0_row),
    .x0_use (x0_use),
    .x1_vld (x1_vld),
    .x1_op  (x1_op),
    .x1_row (x1_row),
    .x1_use (x1_use),
    .stall  (stall)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    localparam int H = b % 2;
    logic               en, we;
    logic [BANK_BE-1:0] be;
    logic [ROW_W-1:0]   row;
    logic [BANK_W-1:0]  wd;

    always_comb begin
      en = x0_use[b] | x1_use[b];
      if (x0_use[b]) begin
        we  = x0_op.we;
        be  = x0_op.be[H*BANK_BE +: BANK_BE];
        row = x0_row;
        wd  = x0_op.wdata[H*BANK_W +: BANK_W];
      end else begin
        we  = x1_op.we;
        be  = x1_op.be[H*BANK_BE +: BANK_BE];
        row = x1_row;
        wd  = x1_op.wdata[H*BANK_W +: BANK_W];
      end
    end

    bdm_bank #(.ROW_W(ROW_W), .WORD_W(BANK_W)) u_bank (
      .clk   (clk),
      .en    (en),
      .we    (we),
      .be    (be),
      .row   (row),
      .wdata (wd),
      .rdata (bank_rd[b])
    );
  end

  always_comb begin
    rv0_d = x0_vld & ~x0_op.we;
    rv1_d = x1_vld & ~x1_op.we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv0_q <= 1'b0;
      rv1_q <= 1'b0;
    end else begin
      rv0_q <= rv0_d;
      rv1_q <= rv1_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rv0_d) pair0_q <= x0_op.pair;
    if (rv1_d) pair1_q <= x1_op.pair;
  end

  always_comb begin
    p0_rdata = '0;
    p1_rdata = '0;
    for (int k = 0; k < N_PAIRS; k++) begin
      if (pair0_q == PAIR_W'(k)) p0_rdata = {bank_rd[2*k+1], bank_rd[2*k]};
      if (pair1_q == PAIR_W'(k)) p1_rdata = {bank_rd[2*k+1], bank_rd[2*k]};
    end
  end

  assign p0_rvalid = rv0_q;
  assign p1_rvalid = rv1_q;
endmodule

// File: rtl/banked_dp_mem_chk.sv
module banked_dp_mem_chk
  import bdm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              p0_valid,
  input logic              p0_we,
  input logic [PAIR_W-1:0] p0_pair,
  input logic              p1_valid,
  input logic              p1_we,
  input logic [PAIR_W-1:0] p1_pair,
  input logic              p0_rvalid,
  input logic              p1_rvalid,
  input logic              stall
);
  AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall); // R6

  AST_P0_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_valid && !p0_we && !stall) |=> p0_rvalid); // R3

  AST_P1_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!p1_valid && !stall) |=> !p1_rvalid); // R3

  AST_DISJOINT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_valid && p1_valid && !stall && (p0_pair != p1_pair)) |=> !stall); // R5

  AST_READ_CLASH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_valid && p1_valid && !stall && !p0_we && !p1_we && (p0_pair == p1_pair))
      |=> (stall ##1 p1_rvalid)); // R6

  AST_STALL_DROPS_P0: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !p0_rvalid); // R9
endmodule

bind banked_dp_mem banked_dp_mem_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .p0_valid  (p0_valid),
  .p0_we     (p0_we),
  .p0_pair   (p0_addr[bdm_pkg::ROW_LSB-1:bdm_pkg::OFF_W]),
  .p1_valid  (p1_valid),
  .p1_we     (p1_we),
  .p1_pair   (p1_addr[bdm_pkg::ROW_LSB-1:bdm_pkg::OFF_W]),
  .p0_rvalid (p0_rvalid),
  .p1_rvalid (p1_rvalid),
  .stall     (stall)
);

// File: tb/banked_dp_mem_test.sv
`timescale 1ns/1ps
module banked_dp_mem_test;
  localparam int AW = 12;
  localparam int NDW = 512;

  logic clk, rst_n;
  logic p0_valid, p0_we, p1_valid, p1_we;
  logic [AW-1:0] p0_addr, p1_addr;
  logic [63:0] p0_wdata, p1_wdata, p0_rdata, p1_rdata;
  logic [7:0] p0_be, p1_be;
  logic p0_rvalid, p1_rvalid, stall;

  banked_dp_mem #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .p0_valid(p0_valid), .p0_we(p0_we), .p0_addr(p0_addr), .p0_wdata(p0_wdata),
    .p0_be(p0_be), .p0_rdata(p0_rdata), .p0_rvalid(p0_rvalid),
    .p1_valid(p1_valid), .p1_we(p1_we), .p1_addr(p1_addr), .p1_wdata(p1_wdata),
    .p1_be(p1_be), .p1_rdata(p1_rdata), .p1_rvalid(p1_rvalid),
    .stall(stall)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int cyc;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit mon_on = 0;
  logic [63:0] ref_mem [NDW];

  int e0c[$]; logic [63:0] e0d[$]; string e0t[$];
  int e1c[$]; logic [63:0] e1d[$]; string e1t[$];

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] use_mask(logic we, logic [AW-1:0] a, logic [7:0] be);
    logic [7:0] m;
    int k;
    m = '0;
    k = int'(a[4:3]);
    if (we) begin
      m[2*k]   = |be[3:0];
      m[2*k+1] = |be[7:4];
    end else begin
      m[2*k]   = 1'b1;
      m[2*k+1] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [63:0] merge(logic [63:0] old, logic [63:0] d, logic [7:0] be);
    logic [63:0] r;
    r = old;
    for (int i = 0; i < 8; i++) if (be[i]) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  task automatic idle();
    p0_valid = 0; p0_we = 0; p0_addr = '0; p0_wdata = '0; p0_be = '0;
    p1_valid = 0; p1_we = 0; p1_addr = '0; p1_wdata = '0; p1_be = '0;
  endtask

  // Driver: called at a falling edge; pushes expected reads to the scoreboard.
  task automatic issue(bit v0, bit w0, logic [AW-1:0] a0, logic [63:0] d0, logic [7:0] b0,
                       bit v1, bit w1, logic [AW-1:0] a1, logic [63:0] d1, logic [7:0] b1,
                       string tag, bit poke);
    logic [7:0] u0, u1;
    bit conf;
    u0 = v0 ? use_mask(w0, a0, b0) : 8'h00;
    u1 = v1 ? use_mask(w1, a1, b1) : 8'h00;
    conf = v0 && v1 && (|(u0 & u1));
    p0_valid = v0; p0_we = w0; p0_addr = a0; p0_wdata = d0; p0_be = b0;
    p1_valid = v1; p1_we = w1; p1_addr = a1; p1_wdata = d1; p1_be = b1;
    if (v0) begin
      if (w0) ref_mem[a0 >> 3] = merge(ref_mem[a0 >> 3], d0, b0);
      else begin e0c.push_back(cyc + 1); e0d.push_back(ref_mem[a0 >> 3]); e0t.push_back(tag); end
    end
    if (v1) begin
      if (w1) ref_mem[a1 >> 3] = merge(ref_mem[a1 >> 3], d1, b1);
      else begin
        e1c.push_back(conf ? cyc + 2 : cyc + 1);
        e1d.push_back(ref_mem[a1 >> 3]);
        e1t.push_back(tag);
      end
    end
    @(posedge clk); @(negedge clk);
    chk(stall === conf, {tag, " stall after request"}, 64'(stall), 64'(conf));
    if (conf) begin
      if (poke) begin
        // R9: these must be dropped
        p0_valid = 1; p0_we = 1; p0_addr = 12'h180; p0_wdata = 64'hDEAD_BEEF_0BAD_F00D; p0_be = 8'hFF;
        p1_valid = 1; p1_we = 0; p1_addr = 12'h1C0; p1_wdata = '0; p1_be = 8'hFF;
      end else idle();
      @(posedge clk); @(negedge clk);
      chk(stall === 1'b0, {tag, " R6 stall lasts one cycle"}, 64'(stall), 64'(0));
    end
    idle();
  endtask

  // Monitor: compares returned reads with the scoreboard queues.
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (p0_rvalid) begin
        if (e0c.size() == 0 || e0c[0] != cyc) chk(0, "R3 unexpected p0_rvalid", 64'(cyc), 64'(0));
        else begin
          chk(p0_rdata === e0d[0], {e0t[0], " p0 data"}, p0_rdata, e0d[0]);
          void'(e0c.pop_front()); void'(e0d.pop_front()); void'(e0t.pop_front());
        end
      end else if (e0c.size() > 0 && e0c[0] <= cyc) begin
        chk(0, {e0t[0], " R3 p0 rvalid missing"}, 64'(0), 64'(1));
        void'(e0c.pop_front()); void'(e0d.pop_front()); void'(e0t.pop_front());
      end
      if (p1_rvalid) begin
        if (e1c.size() == 0 || e1c[0] != cyc) chk(0, "R3 R9 unexpected p1_rvalid", 64'(cyc), 64'(0));
        else begin
          chk(p1_rdata === e1d[0], {e1t[0], " p1 data"}, p1_rdata, e1d[0]);
          void'(e1c.pop_front()); void'(e1d.pop_front()); void'(e1t.pop_front());
        end
      end else if (e1c.size() > 0 && e1c[0] <= cyc) begin
        chk(0, {e1t[0], " R3 p1 rvalid missing"}, 64'(0), 64'(1));
        void'(e1c.pop_front()); void'(e1d.pop_front()); void'(e1t.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 64'(cyc), 64'(0));
    finish_run();
  end

  initial begin
    logic [31:0] lf;
    rst_n = 0;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk(stall === 1'b0, "R1 stall after reset", 64'(stall), 64'(0));
    chk(p0_rvalid === 1'b0, "R1 p0_rvalid after reset", 64'(p0_rvalid), 64'(0));
    chk(p1_rvalid === 1'b0, "R1 p1_rvalid after reset", 64'(p1_rvalid), 64'(0));
    mon_on = 1;

    for (int i = 0; i < NDW; i++) begin
      ref_mem[i] = '0;
      issue(1, 1, AW'(i * 8), {32'(i) ^ 32'hA5A5_0000, 32'(i * 3 + 7)}, 8'hFF,
            0, 0, '0, '0, '0, "R2 fill", 0);
    end

    for (int i = 0; i < 16; i++)
      issue(1, 0, AW'(i * 8), '0, 8'hFF, 1, 0, AW'(i * 8 + 16), '0, 8'hFF, "R5 R2 disjoint reads", 0);

    issue(1, 0, 12'h000, '0, 8'hFF, 1, 0, 12'h008, '0, 8'hFF, "R2 adjacent pairs", 0);
    issue(1, 0, 12'h008, '0, 8'hFF, 1, 0, 12'h028, '0, 8'hFF, "R6 same pair reads", 0);

    issue(1, 1, 12'h040, 64'h1111_1111_1111_1111, 8'h0F,
          1, 1, 12'h040, 64'h2222_2222_2222_2222, 8'hF0, "R7 opposite halves", 0);
    issue(1, 0, 12'h040, '0, 8'hFF, 0, 0, '0, '0, '0, "R7 halves readback", 0);

    issue(1, 1, 12'h048, 64'h3333_3333_3333_3333, 8'h0F,
          1, 1, 12'h068, 64'h4444_4444_4444_4444, 8'h03, "R7 same half clash", 0);
    issue(0, 0, '0, '0, '0, 1, 0, 12'h068, '0, 8'h00, "R7 R4 readback", 0);

    issue(1, 1, 12'h050, 64'h0123_4567_89AB_CDEF, 8'b1010_0101, 0, 0, '0, '0, '0, "R4 sparse be write", 0);
    issue(0, 0, '0, '0, '0, 1, 0, 12'h050, '0, 8'h00, "R4 read ignores be", 0);

    issue(1, 1, 12'h100, 64'hAAAA_0000_AAAA_0000, 8'hFF,
          1, 1, 12'h100, 64'h5555_FFFF_5555_FFFF, 8'hFF, "R8 same location writes", 0);
    issue(1, 0, 12'h100, '0, 8'hFF, 0, 0, '0, '0, '0, "R8 port1 value kept", 0);

    issue(1, 1, 12'h120, 64'hFEED_FACE_CAFE_BABE, 8'hFF,
          1, 0, 12'h120, '0, 8'hFF, "R10 write then read same word", 0);

    issue(1, 0, 12'h200, '0, 8'hFF, 1, 0, 12'h220, '0, 8'hFF, "R9 clash with poke", 1);
    issue(1, 0, 12'h180, '0, 8'hFF, 0, 0, '0, '0, '0, "R9 poked write dropped", 0);

    lf = 32'h1D2C_3B4A;
    for (int i = 0; i < 120; i++) begin
      logic [31:0] r0, r1;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      r0 = lf * 32'h9E37_79B9;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      r1 = lf * 32'h85EB_CA6B;
      issue(1, r0[31], {r0[8:0], 3'b000}, {r0, r1}, r0[23:16],
            1, r1[31], {r1[8:0], 3'b000}, {r1, r0}, r1[23:16], "R5 R6 R8 mixed traffic", 0);
    end

    repeat (4) @(negedge clk);
    chk(e0c.size() == 0 && e1c.size() == 0, "R3 all reads returned",
        64'(e0c.size() + e1c.size()), 64'(0));
    finish_run();
  end
endmodule